// File: doc/BRIEF.md
# Peripheral Control and Status Register Slave

This block is the bus-facing register set of a small peripheral. It answers single transfers on a Wishbone classic slave port and gives each address its own access rule:
- one control word can be read and written;
- one data word feeds a converter-style sink and cannot be read back;
- one identification word can be read but not written;
- one address is a command port on writes and a status port on reads;
- one address exposes an interrupt flag that software clears by writing a one.

A transfer is taken when both the cycle and strobe inputs are high. The acknowledge is registered and lasts one cycle. Read data is registered too, and is valid in the same cycle as the acknowledge. At all other times the read data bus is zero. The peripheral side supplies a running indication and a one-cycle interrupt event. In return it receives an enable level, a command pulse with its code, the sink data word and a masked interrupt request.

Top module: `periph_csr_block`

## Requirements
- R1: A transfer is taken in a cycle where cyc_i and stb_i are both high and ack_o is low. ack_o is high in the following cycle and only in that cycle for that transfer.
- R2: dat_o is all zeros except in the ack cycle of a read (we_i=0). In that cycle it carries the value of the addressed register as it was at the end of the request cycle.
- R3: Address 0 is read/write control. A write stores bit 0 (interrupt enable) and bit 1 (peripheral enable). A read returns those two bits in the same positions, with zeros above. en_o follows bit 1.
- R4: Address 1 is write-only. A write loads dac_o from the low DAC_W bits of the write data. A read returns zero.
- R5: Address 4 is read-only and returns the parameter ID_VAL. A write to it changes no output and no later read value.
- R6: Address 2 is command/status. A write drives cmd_go_o high for exactly the ack cycle, and cmd_code_o then holds the low CMD_W bits of the write data. A read returns the status word: interrupt-active in bit 0, interrupt enable in bit 1, run_i in bit 2, zeros above. It never returns the written value.
- R7: A one-cycle pulse on evt_i sets the interrupt-active flag. A read of address 3 returns that flag in bit 0, with zeros above.
- R8: A write to address 3 with bit 0 set clears the flag. The other bits of that write are ignored, and a write with bit 0 clear leaves the flag unchanged.
- R9: When an event and a clear fall in the same cycle, the flag ends up set.
- R10: irq_o is high exactly when the interrupt-active flag and the interrupt enable bit are both set.
- R11: Addresses 5 to 7 are unmapped. Reads of them return zero. Writes to them are acknowledged and change no output.
- R12: When only one of cyc_i and stb_i is high, there is no acknowledge and no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_i | input | 1 | Bus cycle in progress |
| stb_i | input | 1 | Transfer strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| adr_i | input | ADR_W | Register word address |
| dat_i | input | DATA_W | Write data |
| dat_o | output | DATA_W | Registered read data |
| ack_o | output | 1 | One-cycle acknowledge |
| run_i | input | 1 | Peripheral running indication |
| evt_i | input | 1 | One-cycle interrupt event |
| en_o | output | 1 | Peripheral enable |
| irq_o | output | 1 | Masked interrupt request |
| cmd_go_o | output | 1 | Command pulse |
| cmd_code_o | output | CMD_W | Last command code |
| dac_o | output | DAC_W | Sink data word |

## Verification
The assertions watch the handshake and the interrupt flag on every cycle:
- the single-cycle acknowledge;
- no acknowledge without both strobes;
- a quiet read bus outside read acknowledges;
- the command pulse confined to an acknowledge;
- an event that always leaves the flag set;
- a flag that falls only after a clearing write.

Per-address behaviour can only be shown by the bench scenarios:
- write-only and unmapped reads returning zero;
- writes to the identification word being ignored;
- the status word differing from the written command;
- the set-over-clear tie.

The bench checks these against a model of the register contents.

// File: rtl/csr_pkg.sv
package csr_pkg;

    // word addresses; the bench and software depend on these
    localparam int unsigned ADDR_CTRL = 0;
    localparam int unsigned ADDR_DAC  = 1;
    localparam int unsigned ADDR_CMD  = 2;
    localparam int unsigned ADDR_IRQ  = 3;
    localparam int unsigned ADDR_ID   = 4;

    // field positions
    localparam int unsigned CTRL_IRQEN_BIT = 0;
    localparam int unsigned CTRL_EN_BIT    = 1;
    localparam int unsigned ST_ACT_BIT     = 0;
    localparam int unsigned ST_IRQEN_BIT   = 1;
    localparam int unsigned ST_RUN_BIT     = 2;
    localparam int unsigned IRQ_CLR_BIT    = 0;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_DAC,
        SEL_CMD,
        SEL_IRQ,
        SEL_ID
    } reg_sel_t;

    typedef struct packed {
        logic     wr;
        logic     rd;
        reg_sel_t sel;
    } csr_op_t;

    function automatic reg_sel_t decode_addr(input int unsigned a);
        case (a)
            ADDR_CTRL: return SEL_CTRL;
            ADDR_DAC:  return SEL_DAC;
            ADDR_CMD:  return SEL_CMD;
            ADDR_IRQ:  return SEL_IRQ;
            ADDR_ID:   return SEL_ID;
            default:   return SEL_NONE;
        endcase
    endfunction

    function automatic logic [2:0] status_bits(input logic run, input logic ien, input logic act);
        logic [2:0] s;
        s = '0;
        s[ST_RUN_BIT]   = run;
        s[ST_IRQEN_BIT] = ien;
        s[ST_ACT_BIT]   = act;
        return s;
    endfunction

endpackage

// File: rtl/csr_bus_slave.sv
module csr_bus_slave
    import csr_pkg::*;
#(
    parameter int ADR_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cyc,
    input  logic             stb,
    input  logic             we,
    input  logic [ADR_W-1:0] adr,
    output logic             ack,
    output csr_op_t          op
);
    logic take;

    assign take = cyc && stb && !ack;

    always_comb begin
        op     = '0;
        op.sel = decode_addr(32'(adr));
        if (take) begin
            op.wr = we;
            op.rd = !we;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ack <= 1'b0;
        else     ack <= take;
    end
endmodule

// File: rtl/csr_irq_flag.sv
module csr_irq_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_evt,
    input  logic clr_req,
    output logic active
);
    always_ff @(posedge clk) begin
        if (rst)          active <= 1'b0;
        else if (set_evt) active <= 1'b1;   // set has priority
        else if (clr_req) active <= 1'b0;
    end
endmodule

// File: rtl/csr_regs.sv
module csr_regs
    import csr_pkg::*;
#(
    parameter int              DATA_W = 32,
    parameter int              CMD_W  = 8,
    parameter int              DAC_W  = 12,
    parameter logic [DATA_W-1:0] ID_VAL = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  csr_op_t           op,
    input  logic [DATA_W-1:0] wdata,
    input  logic              run,
    input  logic              irq_act,
    output logic              irq_en,
    output logic              per_en,
    output logic [DAC_W-1:0]  dac,
    output logic              cmd_go,
    output logic [CMD_W-1:0]  cmd_code,
    output logic              clr_req,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] rmux;

    // clear request assigned on every path; held low on reads
    always_comb begin
        clr_req = 1'b0;
        if (op.wr && op.sel == SEL_IRQ) clr_req = wdata[IRQ_CLR_BIT];
    end

    always_comb begin
        rmux = '0;
        case (op.sel)
            SEL_CTRL: begin
                rmux[CTRL_IRQEN_BIT] = irq_en;
                rmux[CTRL_EN_BIT]    = per_en;
            end
            SEL_CMD:  rmux[2:0] = status_bits(run, irq_en, irq_act);
            SEL_IRQ:  rmux[0]   = irq_act;
            SEL_ID:   rmux      = ID_VAL;
            default:  rmux      = '0;   // write-only and unmapped
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_en   <= 1'b0;
            per_en   <= 1'b0;
            dac      <= '0;
            cmd_go   <= 1'b0;
            cmd_code <= '0;
            rdata    <= '0;
        end else begin
            cmd_go <= 1'b0;
            rdata  <= op.rd ? rmux : '0;
            if (op.wr) begin
                case (op.sel)
                    SEL_CTRL: begin
                        irq_en <= wdata[CTRL_IRQEN_BIT];
                        per_en <= wdata[CTRL_EN_BIT];
                    end
                    SEL_DAC: dac <= wdata[DAC_W-1:0];
                    SEL_CMD: begin
                        cmd_go   <= 1'b1;
                        cmd_code <= wdata[CMD_W-1:0];
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/periph_csr_block.sv
module periph_csr_block
    import csr_pkg::*;
#(
    parameter int                ADR_W  = 3,
    parameter int                DATA_W = 32,
    parameter int                CMD_W  = 8,
    parameter int                DAC_W  = 12,
    parameter logic [DATA_W-1:0] ID_VAL = 32'h00C5_A1E7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cyc_i,
    input  logic              stb_i,
    input  logic              we_i,
    input  logic [ADR_W-1:0]  adr_i,
    input  logic [DATA_W-1:0] dat_i,
    output logic [DATA_W-1:0] dat_o,
    output logic              ack_o,
    input  logic              run_i,
    input  logic              evt_i,
    output logic              en_o,
    output logic              irq_o,
    output logic              cmd_go_o,
    output logic [CMD_W-1:0]  cmd_code_o,
    output logic [DAC_W-1:0]  dac_o
);
    csr_op_t op;
    logic    irq_act;
    logic    irq_en;
    logic    clr_req;

    csr_bus_slave #(.ADR_W(ADR_W)) u_bus (
        .clk (clk),
        .rst (rst),
        .cyc (cyc_i),
        .stb (stb_i),
        .we  (we_i),
        .adr (adr_i),
        .ack (ack_o),
        .op  (op)
    );

    csr_regs #(
        .DATA_W (DATA_W),
        .CMD_W  (CMD_W),
        .DAC_W  (DAC_W),
        .ID_VAL (ID_VAL)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .op       (op),
        .wdata    (dat_i),
        .run      (run_i),
        .irq_act  (irq_act),
        .irq_en   (irq_en),
        .per_en   (en_o),
        .dac      (dac_o),
        .cmd_go   (cmd_go_o),
        .cmd_code (cmd_code_o),
        .clr_req  (clr_req),
        .rdata    (dat_o)
    );

    csr_irq_flag u_flag (
        .clk     (clk),
        .rst     (rst),
        .set_evt (evt_i),
        .clr_req (clr_req),
        .active  (irq_act)
    );

    assign irq_o = irq_act & irq_en;
endmodule

// File: rtl/csr_chk.sv
module csr_chk
    import csr_pkg::*;
#(
    parameter int ADR_W  = 3,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              cyc_i,
    input logic              stb_i,
    input logic              we_i,
    input logic [ADR_W-1:0]  adr_i,
    input logic [DATA_W-1:0] dat_i,
    input logic [DATA_W-1:0] dat_o,
    input logic              ack_o,
    input logic              evt_i,
    input logic              irq_act,
    input logic              cmd_go_o
);
    logic clr_wr;
    assign clr_wr = cyc_i && stb_i && we_i && !ack_o
                    && (32'(adr_i) == ADDR_IRQ) && dat_i[IRQ_CLR_BIT];

    // R1
    ack_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        (cyc_i && stb_i && !ack_o) |=> ack_o);

    // R1
    ack_single_chk: assert property (@(posedge clk) disable iff (rst)
        ack_o |=> !ack_o);

    // R12
    no_req_no_ack_chk: assert property (@(posedge clk) disable iff (rst)
        !(cyc_i && stb_i) |=> !ack_o);

    // R2
    dat_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !ack_o |-> (dat_o == '0));

    // R2
    dat_write_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_o && !$past(rst) && $past(we_i)) |-> (dat_o == '0));

    // R6
    cmd_in_ack_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_go_o |-> ack_o);

    // R9
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(evt_i)) |-> irq_act);

    // R8
    fall_by_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(irq_act) |-> $past(clr_wr));
endmodule

bind periph_csr_block csr_chk #(.ADR_W(ADR_W), .DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cyc_i    (cyc_i),
    .stb_i    (stb_i),
    .we_i     (we_i),
    .adr_i    (adr_i),
    .dat_i    (dat_i),
    .dat_o    (dat_o),
    .ack_o    (ack_o),
    .evt_i    (evt_i),
    .irq_act  (irq_act),
    .cmd_go_o (cmd_go_o)
);

// File: tb/sim_periph_csr_block.sv
`timescale 1ns/1ps
module sim_periph_csr_block;
    localparam int AW = 3;
    localparam int DW = 32;
    localparam int CW = 8;
    localparam int VW = 12;
    localparam logic [DW-1:0] IDV = 32'h00C5_A1E7;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cyc = 0, stb = 0, we = 0, run = 0, evt = 0;
    logic [AW-1:0] adr = '0;
    logic [DW-1:0] wd  = '0;
    logic [DW-1:0] rd;
    logic          ack, en, irq, go;
    logic [CW-1:0] code;
    logic [VW-1:0] dac;

    int n_run  = 0;
    int n_fail = 0;

    // model state
    logic          m_ien = 0, m_en = 0, m_flag = 0;
    logic [VW-1:0] m_dac = '0;
    logic [CW-1:0] m_code = '0;

    always #5 clk = ~clk;

    periph_csr_block #(.ADR_W(AW), .DATA_W(DW), .CMD_W(CW), .DAC_W(VW), .ID_VAL(IDV)) u0 (
        .clk(clk), .rst(rst), .cyc_i(cyc), .stb_i(stb), .we_i(we), .adr_i(adr),
        .dat_i(wd), .dat_o(rd), .ack_o(ack), .run_i(run), .evt_i(evt),
        .en_o(en), .irq_o(irq), .cmd_go_o(go), .cmd_code_o(code), .dac_o(dac)
    );

    task automatic chk(input logic ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] exp_read(input int a, input logic r);
        logic [DW-1:0] v = '0;
        case (a)
            0: begin v[0] = m_ien; v[1] = m_en; end
            2: begin v[0] = m_flag; v[1] = m_ien; v[2] = r; end
            3: v[0] = m_flag;
            4: v = IDV;
            default: v = '0;
        endcase
        return v;
    endfunction

    // one transfer; evt pulses in the request cycle when e=1
    task automatic xfer(input logic w, input int a, input logic [DW-1:0] d, input logic e, input logic r);
        logic [DW-1:0] er;
        logic          is_cmd;
        @(negedge clk);
        cyc = 1; stb = 1; we = w; adr = AW'(a); wd = d; evt = e; run = r;
        er = exp_read(a, r);
        is_cmd = w && (a == 2);
        if (w) begin
            case (a)
                0: begin m_ien = d[0]; m_en = d[1]; end
                1: m_dac = d[VW-1:0];
                2: m_code = d[CW-1:0];
                default: ;
            endcase
        end
        if (e) m_flag = 1'b1;                       // R9 set wins
        else if (w && a == 3 && d[0]) m_flag = 1'b0; // R8
        @(negedge clk);
        chk(ack == 1'b1, "R1 ack", DW'(ack), 1);
        if (w) chk(rd == '0, "R2 write ack data", rd, '0);
        else   chk(rd == er, $sformatf("R2/R3-R7/R11 read a=%0d", a), rd, er);
        chk(go == is_cmd, "R6 cmd pulse", DW'(go), DW'(is_cmd));
        cyc = 0; stb = 0; evt = 0;
        chk(en == m_en, "R3 en_o", DW'(en), DW'(m_en));
        chk(dac == m_dac, "R4 dac_o", DW'(dac), DW'(m_dac));
        chk(code == m_code, "R6 cmd_code", DW'(code), DW'(m_code));
        chk(irq == (m_flag & m_ien), "R10 irq", DW'(irq), DW'(m_flag & m_ien));
        @(negedge clk);
        chk(ack == 1'b0 && rd == '0 && go == 1'b0, "R1/R2 idle after ack", {ack, go, 30'(rd != 0)}, '0);
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(ack == 0 && rd == '0 && irq == 0 && en == 0 && dac == '0 && go == 0,
            "R1/R2 reset state", {ack, irq, en, go, 28'(dac)}, '0);

        // R12 partial strobes
        @(negedge clk); cyc = 1; stb = 0; we = 1; adr = 3'd1; wd = 32'hFFF;
        @(negedge clk); chk(ack == 0, "R12 cyc only", DW'(ack), 0);
        cyc = 0; stb = 1;
        @(negedge clk); chk(ack == 0, "R12 stb only", DW'(ack), 0);
        stb = 0;
        @(negedge clk); chk(dac == '0, "R12 no write", DW'(dac), 0);

        // R3 control
        xfer(1, 0, 32'h3, 0, 0);
        xfer(0, 0, 0, 0, 0);
        // R4 write-only
        xfer(1, 1, 32'hABC, 0, 0);
        xfer(0, 1, 0, 0, 0);
        // R5 read-only
        xfer(1, 4, 32'h1234_5678, 0, 0);
        xfer(0, 4, 0, 0, 0);
        // R6 command vs status
        xfer(1, 2, 32'hFFFF_FF5A, 0, 1);
        xfer(0, 2, 0, 0, 1);
        // R7 event sets, R10 irq
        xfer(0, 3, 0, 1, 0);
        xfer(0, 3, 0, 0, 0);
        // R8 bit0=0 ignored, upper bits ignored
        xfer(1, 3, 32'hFFFF_FFFE, 0, 0);
        xfer(0, 3, 0, 0, 0);
        xfer(1, 3, 32'h1, 0, 0);
        xfer(0, 2, 0, 0, 1);
        // R9 same-cycle set and clear
        xfer(1, 3, 32'h1, 1, 0);
        xfer(0, 3, 0, 0, 0);
        // R11 unmapped
        xfer(1, 6, 32'hFFFF_FFFF, 0, 0);
        xfer(0, 7, 0, 0, 0);
        xfer(0, 5, 0, 0, 0);

        // constrained random mix
        for (int i = 0; i < 400; i++) begin
            logic [DW-1:0] d;
            d = $urandom();
            xfer(1'($urandom_range(0, 1)), $urandom_range(0, 7), d,
                 ($urandom_range(0, 5) == 0), 1'($urandom_range(0, 1)));
        end

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule